// File: doc/BRIEF.md
# Memory-Reference Accumulator CPU Core

This block is a 12-bit single-accumulator processor core. It executes the memory-reference part of a classic minicomputer instruction set: bitwise AND, two's-complement add, increment-and-skip-if-zero, deposit-and-clear, jump-to-subroutine and jump. It runs against a 4096-word synchronous memory that returns read data one clock after the address. The core forms each operand address from a short in-page offset. A select bit places that offset either in page zero or in the page of the instruction. An indirect bit makes the addressed word a pointer, and pointers in a small page-zero window are bumped before they are used.

A run level lets the core execute continuously. When the core is halted, each rising edge on the step input runs exactly one whole instruction. The core shows its major state (fetch, defer, execute) and its registers on debug outputs for a front-panel style display.

The sequencer has six named states:
- FETCH_ADDR puts the program counter on the memory address and waits for run or a pending step.
- FETCH_DATA latches the instruction, advances the program counter and forms the effective address.
- DEFER_ADDR and DEFER_DATA read the pointer word, and write it back when it is in the auto-increment window.
- EXEC_ADDR either performs the store operations (deposit-and-clear, jump-to-subroutine) or issues the operand read.
- EXEC_DATA completes AND, add and increment-and-skip.

The transitions are:
- FETCH_ADDR goes to FETCH_DATA on go.
- FETCH_DATA returns to FETCH_ADDR for an unused opcode or a direct jump. It goes to DEFER_ADDR when the indirect bit is set, and to EXEC_ADDR otherwise.
- DEFER_ADDR always goes to DEFER_DATA.
- DEFER_DATA returns to FETCH_ADDR for a jump and goes to EXEC_ADDR otherwise.
- EXEC_ADDR returns to FETCH_ADDR for the two store operations and goes to EXEC_DATA otherwise.
- EXEC_DATA always returns to FETCH_ADDR.

Top module: `acc_cpu_core`

## Requirements
- R1: A synchronous active-high reset clears the accumulator and link, loads the program counter with 0200 octal, and leaves the core halted in fetch (cpu_state 0).
- R2: Opcode 0 (instruction bits 11:9) replaces the accumulator with the bitwise AND of accumulator and operand, and leaves the link unchanged.
- R3: Opcode 1 adds the operand to the accumulator modulo 4096 and complements the link when the 12-bit sum carries out.
- R4: Opcode 2 writes operand+1 (modulo 4096) back to the operand address. It skips the next instruction (program counter +2 instead of +1) exactly when that result is zero.
- R5: Opcode 3 writes the accumulator to the operand address and then clears the accumulator. Memory is never written during fetch.
- R6: Opcode 4 stores the address of the following instruction at the effective address and continues at the effective address +1.
- R7: Opcode 5 loads the effective address into the program counter.
- R8: The offset is bits 6:0. When bit 7 is 0 the offset addresses page zero. When bit 7 is 1 the address is the upper five bits of the instruction's own address joined with the offset, even when the instruction sits in the last word of a page.
- R9: When bit 8 is set, the word at the effective address is used as the operand address (defer state, cpu_state 1). Pointers outside 010 to 017 octal are not modified.
- R10: An indirect reference through page-zero words 010 to 017 octal writes pointer+1 (modulo 4096) back and uses the incremented value as the operand address or jump target.
- R11: Opcodes 6 and 7 are no-operations: accumulator, link and memory are unchanged and the program counter advances by one, whatever the indirect bit says.
- R12: With run low and no step, the program counter holds. Each rising edge of step executes exactly one instruction, even if step stays high.
- R13: With run high, instructions execute back to back. cpu_state only shows 0 (fetch), 1 (defer) or 2 (execute), and defer is entered only from fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Continuous execution enable |
| step_req | input | 1 | Rising edge requests one instruction |
| mem_rdata | input | 12 | Memory read data, valid one cycle after the address |
| mem_addr | output | 12 | Memory word address |
| mem_wr | output | 1 | Memory write strobe for this cycle |
| mem_wdata | output | 12 | Memory write data |
| cpu_state | output | 2 | Major state: 0 fetch, 1 defer, 2 execute |
| dbg_pc | output | 12 | Program counter |
| dbg_ac | output | 12 | Accumulator |
| dbg_link | output | 1 | Link bit |
| dbg_ma | output | 12 | Memory address register |
| dbg_ir | output | 12 | Instruction register |
| halted | output | 1 | Core is idle in fetch with nothing to start |

## Verification
The add and AND paths are swept over all pairs of a 16-value operand set that includes zero, one, all ones, the sign bit alone and its complement. This separates a wrong carry-into-link from a wrong sum, and shows up missing bits in the AND. Increment-and-skip runs over the same set, so the all-ones operand is the only one that takes the skip. Addressing is tried in several pages and at the last word of a page, so a design that takes the page from the advanced program counter is caught. All eight auto-increment pointers are tried, as are the non-incrementing neighbours 007 and 020 octal and a wrapping pointer, so the window bounds and the write-back are pinned down. Unused opcodes, a held step input and a free-running loop through an indirect jump cover the no-operation, stepping and major-state order.

// File: rtl/acc_cpu_pkg.sv
`timescale 1ns/1ps
package acc_cpu_pkg;

    typedef enum logic [2:0] {
        ST_FETCH_ADDR,
        ST_FETCH_DATA,
        ST_DEFER_ADDR,
        ST_DEFER_DATA,
        ST_EXEC_ADDR,
        ST_EXEC_DATA
    } seq_state_t;

    typedef enum logic [2:0] {
        OP_AND  = 3'd0,
        OP_TAD  = 3'd1,
        OP_ISZ  = 3'd2,
        OP_DCA  = 3'd3,
        OP_JMS  = 3'd4,
        OP_JMP  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } opcode_t;

    localparam logic [1:0] MAJ_FETCH = 2'd0;
    localparam logic [1:0] MAJ_DEFER = 2'd1;
    localparam logic [1:0] MAJ_EXEC  = 2'd2;

endpackage

// File: rtl/acc_cpu_seq.sv
`timescale 1ns/1ps
module acc_cpu_seq
    import acc_cpu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  opcode_t    op,
    input  logic       ind,
    output seq_state_t state
);

    seq_state_t state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH_ADDR;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH_ADDR: state_nx = go ? ST_FETCH_DATA : ST_FETCH_ADDR;
            ST_FETCH_DATA: begin
                if (op == OP_RSV6 || op == OP_RSV7) state_nx = ST_FETCH_ADDR;
                else if (ind)                       state_nx = ST_DEFER_ADDR;
                else if (op == OP_JMP)              state_nx = ST_FETCH_ADDR;
                else                                state_nx = ST_EXEC_ADDR;
            end
            ST_DEFER_ADDR: state_nx = ST_DEFER_DATA;
            ST_DEFER_DATA: state_nx = (op == OP_JMP) ? ST_FETCH_ADDR : ST_EXEC_ADDR;
            ST_EXEC_ADDR:  state_nx = (op == OP_DCA || op == OP_JMS) ? ST_FETCH_ADDR : ST_EXEC_DATA;
            ST_EXEC_DATA:  state_nx = ST_FETCH_ADDR;
            default:       state_nx = ST_FETCH_ADDR;
        endcase
    end

endmodule

// File: rtl/acc_cpu_ea.sv
`timescale 1ns/1ps
module acc_cpu_ea #(
    parameter int WORD_W     = 12,
    parameter int OFS_W      = 7,
    parameter int AUTO_BASE  = 8,
    parameter int AUTO_COUNT = 8
) (
    input  logic [OFS_W:0]        sel_ofs,   // page-select bit above the offset
    input  logic [WORD_W-1:OFS_W] ipage,     // page bits of the instruction's address
    input  logic [WORD_W-1:0]     ptr_addr,
    output logic [WORD_W-1:0]     ea,
    output logic                  ptr_auto
);

    localparam int PAGE_W = WORD_W - OFS_W;
    localparam logic [WORD_W-1:0] AUTO_LO = WORD_W'(AUTO_BASE);
    localparam logic [WORD_W-1:0] AUTO_HI = WORD_W'(AUTO_BASE + AUTO_COUNT - 1);

    always_comb begin
        if (sel_ofs[OFS_W]) ea = {ipage, sel_ofs[OFS_W-1:0]};
        else                ea = {{PAGE_W{1'b0}}, sel_ofs[OFS_W-1:0]};
    end

    assign ptr_auto = (ptr_addr >= AUTO_LO) && (ptr_addr <= AUTO_HI);

endmodule

// File: rtl/acc_cpu_alu.sv
`timescale 1ns/1ps
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  opcode_t           op,
    input  logic [WORD_W-1:0] ac,
    input  logic              link,
    input  logic [WORD_W-1:0] mdata,
    output logic [WORD_W-1:0] ac_res,
    output logic              link_res,
    output logic [WORD_W-1:0] inc_res,
    output logic              inc_zero
);

    localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

    logic [WORD_W:0] sum;

    assign sum      = {1'b0, ac} + {1'b0, mdata};
    assign inc_res  = mdata + ONE;
    assign inc_zero = (inc_res == '0);

    always_comb begin
        ac_res   = ac;
        link_res = link;
        unique case (op)
            OP_AND: ac_res = ac & mdata;
            OP_TAD: begin
                ac_res   = sum[WORD_W-1:0];
                link_res = link ^ sum[WORD_W];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/acc_cpu_core.sv
`timescale 1ns/1ps
module acc_cpu_core
    import acc_cpu_pkg::*;
#(
    parameter int WORD_W     = 12,
    parameter int OFS_W      = 7,
    parameter int AUTO_BASE  = 8,
    parameter int AUTO_COUNT = 8,
    parameter int RESET_PC   = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              step_req,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [1:0]        cpu_state,
    output logic [WORD_W-1:0] dbg_pc,
    output logic [WORD_W-1:0] dbg_ac,
    output logic              dbg_link,
    output logic [WORD_W-1:0] dbg_ma,
    output logic [WORD_W-1:0] dbg_ir,
    output logic              halted
);

    localparam int OPC_MSB = WORD_W - 1;
    localparam int OPC_LSB = WORD_W - 3;
    localparam int IND_BIT = OFS_W + 1;
    localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

    logic [WORD_W-1:0] pc, ac, ma, ir;
    logic              lnk;
    logic              step_q, step_pend;
    seq_state_t        st;
    opcode_t           op_now;
    logic              ind_now;
    logic              go, launch;
    logic [WORD_W-1:0] ea, ptr_val;
    logic              ptr_auto;
    logic [WORD_W-1:0] ac_res, inc_res;
    logic              link_res, inc_zero;

    // During FETCH_DATA the instruction is still on the read bus.
    assign op_now  = (st == ST_FETCH_DATA) ? opcode_t'(mem_rdata[OPC_MSB:OPC_LSB])
                                           : opcode_t'(ir[OPC_MSB:OPC_LSB]);
    assign ind_now = (st == ST_FETCH_DATA) ? mem_rdata[IND_BIT] : ir[IND_BIT];
    assign go      = run_en | step_pend;
    assign launch  = (st == ST_FETCH_ADDR) && go;
    assign ptr_val = ptr_auto ? inc_res : mem_rdata;

    acc_cpu_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .go    (go),
        .op    (op_now),
        .ind   (ind_now),
        .state (st)
    );

    acc_cpu_ea #(
        .WORD_W     (WORD_W),
        .OFS_W      (OFS_W),
        .AUTO_BASE  (AUTO_BASE),
        .AUTO_COUNT (AUTO_COUNT)
    ) u_ea (
        .sel_ofs  (mem_rdata[OFS_W:0]),
        .ipage    (pc[WORD_W-1:OFS_W]),
        .ptr_addr (ma),
        .ea       (ea),
        .ptr_auto (ptr_auto)
    );

    acc_cpu_alu #(.WORD_W(WORD_W)) u_alu (
        .op       (op_now),
        .ac       (ac),
        .link     (lnk),
        .mdata    (mem_rdata),
        .ac_res   (ac_res),
        .link_res (link_res),
        .inc_res  (inc_res),
        .inc_zero (inc_zero)
    );

    // Register file and step request.
    always_ff @(posedge clk) begin
        if (rst) begin
            pc        <= WORD_W'(RESET_PC);
            ac        <= '0;
            lnk       <= 1'b0;
            ma        <= '0;
            ir        <= '0;
            step_q    <= 1'b0;
            step_pend <= 1'b0;
        end else begin
            step_q    <= step_req;
            step_pend <= (step_pend & ~launch) | (step_req & ~step_q);
            unique case (st)
                ST_FETCH_DATA: begin
                    ir <= mem_rdata;
                    ma <= ea;
                    if (op_now == OP_JMP && !ind_now) pc <= ea;
                    else                              pc <= pc + ONE;
                end
                ST_DEFER_DATA: begin
                    ma <= ptr_val;
                    if (op_now == OP_JMP) pc <= ptr_val;
                end
                ST_EXEC_ADDR: begin
                    if (op_now == OP_DCA)      ac <= '0;
                    else if (op_now == OP_JMS) pc <= ma + ONE;
                end
                ST_EXEC_DATA: begin
                    if (op_now == OP_ISZ) begin
                        if (inc_zero) pc <= pc + ONE;
                    end else begin
                        ac  <= ac_res;
                        lnk <= link_res;
                    end
                end
                default: ;
            endcase
        end
    end

    // Memory strobes and display outputs.
    always_comb begin
        mem_addr  = ma;
        mem_wr    = 1'b0;
        mem_wdata = ac;
        cpu_state = MAJ_FETCH;
        unique case (st)
            ST_FETCH_ADDR, ST_FETCH_DATA: begin
                mem_addr  = pc;
                cpu_state = MAJ_FETCH;
            end
            ST_DEFER_ADDR: cpu_state = MAJ_DEFER;
            ST_DEFER_DATA: begin
                cpu_state = MAJ_DEFER;
                mem_wr    = ptr_auto;
                mem_wdata = inc_res;
            end
            ST_EXEC_ADDR: begin
                cpu_state = MAJ_EXEC;
                mem_wr    = (op_now == OP_DCA) || (op_now == OP_JMS);
                mem_wdata = (op_now == OP_JMS) ? pc : ac;
            end
            ST_EXEC_DATA: begin
                cpu_state = MAJ_EXEC;
                mem_wr    = (op_now == OP_ISZ);
                mem_wdata = inc_res;
            end
            default: ;
        endcase
    end

    assign dbg_pc   = pc;
    assign dbg_ac   = ac;
    assign dbg_link = lnk;
    assign dbg_ma   = ma;
    assign dbg_ir   = ir;
    assign halted   = (st == ST_FETCH_ADDR) && !go;

endmodule

// File: rtl/acc_cpu_core_chk.sv
`timescale 1ns/1ps
module acc_cpu_core_chk #(
    parameter int WORD_W   = 12,
    parameter int RESET_PC = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_wr,
    input logic [1:0]        cpu_state,
    input logic [WORD_W-1:0] dbg_pc,
    input logic [WORD_W-1:0] dbg_ac,
    input logic              dbg_link,
    input logic              halted
);

    localparam logic [1:0] C_FETCH = 2'd0;
    localparam logic [1:0] C_DEFER = 2'd1;
    localparam logic [1:0] C_EXEC  = 2'd2;

    logic rst_q;
    logic past_ok;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    assert_reset_vector_R1: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (dbg_pc == WORD_W'(RESET_PC) && dbg_ac == '0 && !dbg_link && cpu_state == C_FETCH));

    assert_ac_exec_only_R2: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$stable(dbg_ac)) |-> $past(cpu_state) == C_EXEC);

    assert_link_exec_only_R3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$stable(dbg_link)) |-> $past(cpu_state) == C_EXEC);

    assert_write_phase_R5: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> cpu_state != C_FETCH);

    assert_halt_holds_pc_R12: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(dbg_pc));

    assert_state_code_R13: assert property (@(posedge clk) disable iff (rst)
        cpu_state != 2'd3);

    assert_defer_entry_R13: assert property (@(posedge clk) disable iff (rst)
        (past_ok && cpu_state == C_DEFER && $past(cpu_state) != C_DEFER) |-> $past(cpu_state) == C_FETCH);

endmodule

bind acc_cpu_core acc_cpu_core_chk #(
    .WORD_W   (WORD_W),
    .RESET_PC (RESET_PC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_wr    (mem_wr),
    .cpu_state (cpu_state),
    .dbg_pc    (dbg_pc),
    .dbg_ac    (dbg_ac),
    .dbg_link  (dbg_link),
    .halted    (halted)
);

// File: tb/acc_cpu_core_test.sv
`timescale 1ns/1ps
module acc_cpu_core_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic        step_req = 1'b0;
    logic [11:0] mem_rdata;
    logic [11:0] mem_addr, mem_wdata;
    logic        mem_wr;
    logic [1:0]  cpu_state;
    logic [11:0] dbg_pc, dbg_ac, dbg_ma, dbg_ir;
    logic        dbg_link, halted;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int exp_link = 0;

    // bench memory and a poke path used only while the core is halted
    logic [11:0] mem [0:4095];
    logic        tb_we = 1'b0;
    logic [11:0] tb_addr = '0, tb_data = '0;

    always #2 clk = ~clk;   // 4 ns period

    always @(posedge clk) begin
        if (tb_we)       mem[tb_addr] <= tb_data;
        else if (mem_wr) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    acc_cpu_core uut (
        .clk(clk), .rst(rst), .run_en(run_en), .step_req(step_req),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .cpu_state(cpu_state), .dbg_pc(dbg_pc),
        .dbg_ac(dbg_ac), .dbg_link(dbg_link), .dbg_ma(dbg_ma),
        .dbg_ir(dbg_ir), .halted(halted)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0o expected %0o", tag, act, exp);
        end
    endtask

    task automatic poke(input int a, input int d);
        @(negedge clk);
        tb_we = 1'b1; tb_addr = a[11:0]; tb_data = d[11:0];
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic step_one();
        @(negedge clk) step_req = 1'b1;
        @(negedge clk) step_req = 1'b0;
        for (int i = 0; i < 64; i++) begin
            if (halted) break;
            @(negedge clk);
        end
    endtask

    task automatic exec(input int ins);
        poke(int'(dbg_pc), ins);
        step_one();
    endtask

    task automatic home();
        poke('o170, 'o200);
        exec('o5570);
    endtask

    task automatic set_ac(input int v);
        exec('o3177);
        poke('o176, v);
        exec('o1176);
    endtask

    function automatic int val_of(input int k);
        case (k)
            0: return 0;
            1: return 1;
            2: return 'o7777;
            3: return 'o4000;
            4: return 'o3777;
            default: return (k * 'o1357 + 'o42) & 'o7777;
        endcase
    endfunction

    initial begin
        #(4 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 pc", int'(dbg_pc), 'o200);
        check("R1 ac", int'(dbg_ac), 0);
        check("R1 link", int'(dbg_link), 0);
        check("R1 state", int'(cpu_state), 0);
        check("R1 halted", int'(halted), 1);

        // R3 add sweep, R2 AND sweep
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                int a, b, s;
                a = val_of(i); b = val_of(j);
                home();
                set_ac(a);
                poke('o175, b);
                exec('o1175);
                s = a + b;
                exp_link = exp_link ^ (s >> 12);
                check("R3 add ac", int'(dbg_ac), s & 'o7777);
                check("R3 add link", int'(dbg_link), exp_link);
                set_ac(a);
                exec('o0175);
                check("R2 and ac", int'(dbg_ac), a & b);
                check("R2 and link", int'(dbg_link), exp_link);
            end
        end

        // R4 increment and skip
        for (int i = 0; i < 16; i++) begin
            int v, pc0, r;
            v = val_of(i);
            home();
            poke('o174, v);
            pc0 = int'(dbg_pc);
            exec('o2174);
            r = (v + 1) & 'o7777;
            check("R4 isz mem", int'(mem['o174]), r);
            check("R4 isz pc", int'(dbg_pc), (r == 0) ? pc0 + 2 : pc0 + 1);
        end

        // R5 deposit and clear
        for (int i = 0; i < 8; i++) begin
            home();
            set_ac(val_of(i + 3));
            exec('o3173);
            check("R5 dca mem", int'(mem['o173]), val_of(i + 3));
            check("R5 dca ac", int'(dbg_ac), 0);
        end

        // R6 jump to subroutine
        for (int k = 0; k < 8; k++) begin
            int off;
            off = 'o40 + k * 5;
            home();
            exec('o4200 | off);
            check("R6 jms link word", int'(mem['o200 | off]), 'o201);
            check("R6 jms pc", int'(dbg_pc), ('o200 | off) + 1);
        end

        // R7 jump
        home();
        exec('o5257);
        check("R7 jmp current page", int'(dbg_pc), 'o257);
        exec('o5060);
        check("R7 jmp page zero", int'(dbg_pc), 'o60);
        home();
        check("R7 jmp indirect", int'(dbg_pc), 'o200);

        // R8 page addressing in other pages and at a page end
        for (int k = 0; k < 8; k++) begin
            int base, vx, s;
            base = (3 + k * 3) * 128;
            vx = val_of(k + 5);
            home();
            set_ac(0);
            poke('o171, base + 'o60);
            exec('o5571);
            check("R8 reach page", int'(dbg_pc), base + 'o60);
            poke(base + 'o25, vx);
            poke('o25, 1);
            exec('o1225);
            check("R8 current page operand", int'(dbg_ac), vx);
            exec('o1025);
            s = vx + 1;
            exp_link = exp_link ^ (s >> 12);
            check("R8 page zero operand", int'(dbg_ac), s & 'o7777);
            home();
            set_ac(0);
            poke('o171, base + 'o177);
            exec('o5571);
            poke(base + 'o5, vx ^ 'o17);
            poke(base + 'o205, 'o7070);
            exec('o1205);
            check("R8 page end operand", int'(dbg_ac), vx ^ 'o17);
            check("R8 page end pc", int'(dbg_pc), base + 'o200);
        end

        // R10 auto-increment window
        for (int p = 8; p < 16; p++) begin
            int q, v;
            q = 'o5000 + p * 4;
            v = (p * 'o101) & 'o7777;
            home();
            poke(p, q);
            poke(q, 'o1111);
            poke(q + 1, v);
            set_ac(0);
            exec('o1400 | p);
            check("R10 auto operand", int'(dbg_ac), v);
            check("R10 auto pointer", int'(mem[p]), q + 1);
        end
        home();
        poke('o13, 'o7777);
        poke(0, 'o2345);
        set_ac(0);
        exec('o1413);
        check("R10 wrap operand", int'(dbg_ac), 'o2345);
        check("R10 wrap pointer", int'(mem['o13]), 0);
        home();
        poke('o15, 'o6100);
        set_ac('o4321);
        exec('o3415);
        check("R10 dca via auto", int'(mem['o6101]), 'o4321);
        check("R10 dca pointer", int'(mem['o15]), 'o6101);
        poke('o16, 'o377);
        exec('o5416);
        check("R10 jmp via auto", int'(dbg_pc), 'o400);
        check("R10 jmp pointer", int'(mem['o16]), 'o400);

        // R9 indirect without increment
        for (int k = 0; k < 3; k++) begin
            int p, q;
            p = (k == 0) ? 'o7 : ((k == 1) ? 'o20 : 'o30);
            q = 'o6200 + k * 8;
            home();
            poke(p, q);
            poke(q, 'o1357 + k);
            poke(q + 1, 'o7531);
            set_ac(0);
            exec('o1400 | p);
            check("R9 indirect operand", int'(dbg_ac), 'o1357 + k);
            check("R9 pointer unchanged", int'(mem[p]), q);
        end

        // R11 unused opcodes
        for (int k = 0; k < 5; k++) begin
            int ins, pc0, a0, l0;
            case (k)
                0: ins = 'o6000;
                1: ins = 'o6577;
                2: ins = 'o7000;
                3: ins = 'o7042;
                default: ins = 'o7777;
            endcase
            home();
            set_ac('o1234);
            poke('o42, 'o5555);
            a0 = int'(dbg_ac); l0 = int'(dbg_link); pc0 = int'(dbg_pc);
            exec(ins);
            check("R11 nop ac", int'(dbg_ac), a0);
            check("R11 nop link", int'(dbg_link), l0);
            check("R11 nop pc", int'(dbg_pc), pc0 + 1);
            check("R11 nop mem", int'(mem['o42]), 'o5555);
        end

        // R12 halt and step
        begin
            int pc0;
            home();
            pc0 = int'(dbg_pc);
            repeat (20) @(negedge clk);
            check("R12 halted pc", int'(dbg_pc), pc0);
            poke(pc0, 'o7000);
            poke(pc0 + 1, 'o7000);
            poke(pc0 + 2, 'o7000);
            @(negedge clk) step_req = 1'b1;
            repeat (30) @(negedge clk);
            step_req = 1'b0;
            for (int i = 0; i < 64; i++) begin
                if (halted) break;
                @(negedge clk);
            end
            check("R12 held step one instr", int'(dbg_pc), pc0 + 1);
            step_one();
            check("R12 next step", int'(dbg_pc), pc0 + 2);
            check("R12 state fetch", int'(cpu_state), 0);
        end

        // R13 free run through an indirect loop
        begin
            int p, bad, defers, prev, s;
            home();
            set_ac(0);
            p = int'(dbg_pc);
            for (int i = 0; i < 4; i++) poke(p + i, 'o1165);
            poke('o165, 7);
            poke('o166, p + 4);
            poke(p + 4, 'o5566);
            bad = 0; defers = 0; prev = 0;
            @(negedge clk) run_en = 1'b1;
            for (int i = 0; i < 80; i++) begin
                @(negedge clk);
                if (cpu_state == 2'd3) bad++;
                if (cpu_state == 2'd1 && prev == 2) bad++;
                if (cpu_state == 2'd1) defers++;
                prev = int'(cpu_state);
            end
            run_en = 1'b0;
            for (int i = 0; i < 64; i++) begin
                if (halted) break;
                @(negedge clk);
            end
            s = 28;
            check("R13 state order", bad, 0);
            check("R13 defer seen", (defers > 0) ? 1 : 0, 1);
            check("R13 run ac", int'(dbg_ac), s);
            check("R13 run pc", int'(dbg_pc), p + 4);
            check("R13 run link", int'(dbg_link), exp_link);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule